// File: doc/BRIEF.md
# External-Master Register Slave Port

This block is the slave end of a shared synchronous bus. An external master that owns the bus uses it to reach a small bank of internal registers. The master raises a transfer-start strobe, and the port samples that strobe together with the address, the direction and the write data. A strobe is served only while external-master operation is enabled. If the address falls inside a configurable, size-aligned window, the port carries out one single-beat read or write. It then ends the access with exactly one one-cycle termination: acknowledge, transfer error or retry. An address outside the window gets no termination from the port. The port only pulses a hand-off flag, so that a separate chip-select path can serve that access.

A second function works on its own and watches the bus termination lines. Every cycle it classifies them under a fixed precedence. An error wins over everything else. A retry wins over an acknowledge. An acknowledge counts as a normal completion only when the other two lines are quiet. The error line is open-drain and may be released late. For that reason, an error sample that directly follows another error sample is treated as the tail of the earlier error and is not reported again.

Top module: `ext_slave_port`

## Requirements
- R1: While `extMasterEn` is low, a sampled strobe produces no termination and no `passThru` pulse.
- R2: A strobe sampled at clock edge k while idle, with enable high and an in-window address (`busAddr[ADDR_W-1:WIN_LSB]` equal to the same bits of `WIN_BASE`, where `WIN_LSB` = log2(`REG_COUNT`)+2), gives exactly one termination pulse. That pulse is high only between edges k+1 and k+2.
- R3: The register index is `busAddr[WIN_LSB-1:2]`, and register i resets to `RESET_BASE + i`. An acknowledged write stores `busWdata` in the register. An acknowledged read shows that register's value on `rdData` in the acknowledge cycle, and `rdData` holds its value otherwise.
- R4: A misaligned address (`busAddr[1:0]` not zero) or a write to a register whose `RO_MASK` bit is set ends with `errOut` for one cycle and changes no register.
- R5: `busyIn` high when the strobe is sampled ends an otherwise valid access with `retryOut` for one cycle and changes no register.
- R6: At most one of `ackOut`, `errOut` and `retryOut` is high in any cycle. When an access both has an error condition and is busy, it ends with `errOut`.
- R7: An out-of-window strobe, with enable high and the port idle, produces no termination and a one-cycle `passThru` pulse between edges k and k+1.
- R8: A strobe sampled while an access is pending (the edge right after acceptance) is ignored and produces no termination, no `passThru` and no write.
- R9: Registers marked read-only in `RO_MASK` never change after reset.
- R10: The monitor samples the `see*` inputs at each edge. In the next cycle it shows `monValid` high with `monCode` set to 3 if the error line was asserted, else 2 if the retry line was, else 1 if the acknowledge line was. When no line was asserted it shows `monValid` low with code 0.
- R11: An error sample that directly follows an error sample is not reported as an error. That cycle is classified from the retry and acknowledge lines alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMasterEn | input | 1 | Enables serving of external-master accesses |
| busStart | input | 1 | Transfer-start strobe from the master |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWdata | input | DATA_W | Write data |
| busyIn | input | 1 | Internal side busy; forces a retry |
| ackOut | output | 1 | Normal termination pulse |
| errOut | output | 1 | Transfer-error termination pulse |
| retryOut | output | 1 | Retry termination pulse |
| rdData | output | DATA_W | Read data, valid in the acknowledge cycle of a read |
| passThru | output | 1 | Out-of-window hand-off pulse |
| seeAck | input | 1 | Observed bus acknowledge line |
| seeRetry | input | 1 | Observed bus retry line |
| seeErr | input | 1 | Observed bus error line |
| monValid | output | 1 | Classified termination present |
| monCode | output | 2 | 0 none, 1 normal, 2 retry, 3 error |

## Verification
Two things can clash within one access: an error condition (a misaligned address or a read-only write) and a busy retry request. Both are latched from the same strobe sample. The bench raises `busyIn` together with misaligned or read-only writes, both in directed cases and in random ones, and expects only `errOut`. On the monitor side, an error can arrive in the same cycle as retry and acknowledge, and an error can also repeat back to back. The random line patterns cover both cases, and each result is judged against a bench model that tracks the previous error sample.

// File: rtl/esp_pkg.sv
package esp_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address, direction and data of an accepted strobe
    logic commit;   // acknowledged write: update register
    logic load;     // acknowledged read: drive read data
  } dpCtrl_t;

  typedef enum logic [1:0] {
    TERM_NONE   = 2'd0,
    TERM_NORMAL = 2'd1,
    TERM_RETRY  = 2'd2,
    TERM_ERROR  = 2'd3
  } termCode_e;

endpackage

// File: rtl/esp_datapath.sv
module esp_datapath
  import esp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int REG_COUNT = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
  parameter logic [REG_COUNT-1:0] RO_MASK = 8'h81,
  parameter logic [DATA_W-1:0] RESET_BASE = 32'h5A00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic              inWindow,
  output logic              reqMisaligned,
  output logic              reqRoHit,
  output logic              reqWrite,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int WIN_LSB = IDX_W + 2;

  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  reqIdx;
  logic [DATA_W-1:0] reqData;
  logic [DATA_W-1:0] regQ [REG_COUNT];

  assign curIdx   = busAddr[WIN_LSB-1:2];
  assign inWindow = (busAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqIdx        <= '0;
      reqData       <= '0;
      reqWrite      <= 1'b0;
      reqMisaligned <= 1'b0;
      reqRoHit      <= 1'b0;
    end else if (ctrl.capture) begin
      reqIdx        <= curIdx;
      reqData       <= busWdata;
      reqWrite      <= busWrite;
      reqMisaligned <= (busAddr[1:0] != 2'b00);
      reqRoHit      <= busWrite && RO_MASK[curIdx];
    end
  end

  // register array, one writable or fixed slot per index
  for (genvar i = 0; i < REG_COUNT; i++) begin : gSlot
    localparam logic [DATA_W-1:0] INIT = RESET_BASE + DATA_W'(i);
    if (RO_MASK[i]) begin : gFixed
      always_ff @(posedge clk) regQ[i] <= INIT;
      assert_ro_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
        ##1 $stable(regQ[i]));
    end else begin : gRw
      always_ff @(posedge clk) begin
        if (!rstN) regQ[i] <= INIT;
        else if (ctrl.commit && reqIdx == IDX_W'(i)) regQ[i] <= reqData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (ctrl.load) rdData <= regQ[reqIdx];
  end

  // R4: no write may commit for a request that carried an error condition
  assert_no_bad_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |-> (!reqMisaligned && !reqRoHit && reqWrite));

  // R3: commit and load never together
  assert_commit_load_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.commit && ctrl.load));

endmodule

// File: rtl/esp_control.sv
module esp_control
  import esp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    extMasterEn,
  input  logic    busStart,
  input  logic    busyIn,
  input  logic    inWindow,
  input  logic    reqMisaligned,
  input  logic    reqRoHit,
  input  logic    reqWrite,
  output dpCtrl_t ctrl,
  output logic    ackOut,
  output logic    errOut,
  output logic    retryOut,
  output logic    passThru
);
  logic pendQ;
  logic busyQ;
  logic accept;
  logic miss;
  logic selErr;
  logic selRetry;
  logic selAck;

  assign accept = !pendQ && busStart && extMasterEn && inWindow;
  assign miss   = !pendQ && busStart && extMasterEn && !inWindow;

  // fixed precedence: error, then retry, then acknowledge
  assign selErr   = pendQ && (reqMisaligned || reqRoHit);
  assign selRetry = pendQ && !selErr && busyQ;
  assign selAck   = pendQ && !selErr && !busyQ;

  always_comb begin
    ctrl         = '0;
    ctrl.capture = accept;
    ctrl.commit  = selAck && reqWrite;
    ctrl.load    = selAck && !reqWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= 1'b0;
      busyQ    <= 1'b0;
      ackOut   <= 1'b0;
      errOut   <= 1'b0;
      retryOut <= 1'b0;
      passThru <= 1'b0;
    end else begin
      pendQ    <= accept;
      if (accept) busyQ <= busyIn;
      ackOut   <= selAck;
      errOut   <= selErr;
      retryOut <= selRetry;
      passThru <= miss;
    end
  end

  assert_one_term_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ackOut, errOut, retryOut}));

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    errOut |=> !errOut);

  assert_retry_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    retryOut |=> !retryOut);

  assert_term_timing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pendQ && busStart && extMasterEn && inWindow) |-> ##2 (ackOut || errOut || retryOut));

  assert_no_pass_on_term_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut || errOut || retryOut) |-> !passThru);

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!extMasterEn && !pendQ) |=> !passThru);

endmodule

// File: rtl/esp_monitor.sv
module esp_monitor
  import esp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      seeAck,
  input  logic      seeRetry,
  input  logic      seeErr,
  output logic      monValid,
  output termCode_e monCode
);
  logic errPrevQ;
  logic errFresh;
  termCode_e nextCode;

  assign errFresh = seeErr && !errPrevQ;

  always_comb begin
    if (errFresh)      nextCode = TERM_ERROR;
    else if (seeRetry) nextCode = TERM_RETRY;
    else if (seeAck)   nextCode = TERM_NORMAL;
    else               nextCode = TERM_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPrevQ <= 1'b0;
      monValid <= 1'b0;
      monCode  <= TERM_NONE;
    end else begin
      errPrevQ <= seeErr;
      monValid <= (nextCode != TERM_NONE);
      monCode  <= nextCode;
    end
  end

  assert_valid_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    monValid |-> (monCode != TERM_NONE));

  assert_retry_class_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!seeErr && seeRetry) |=> (monValid && monCode == TERM_RETRY));

  assert_err_tail_R11: assert property (@(posedge clk) disable iff (!rstN)
    (seeErr && errPrevQ && !seeRetry && !seeAck) |=> !monValid);

endmodule

// File: rtl/ext_slave_port.sv
module ext_slave_port
  import esp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int REG_COUNT = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
  parameter logic [REG_COUNT-1:0] RO_MASK = 8'h81,
  parameter logic [DATA_W-1:0] RESET_BASE = 32'h5A00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMasterEn,
  input  logic              busStart,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busyIn,
  output logic              ackOut,
  output logic              errOut,
  output logic              retryOut,
  output logic [DATA_W-1:0] rdData,
  output logic              passThru,
  input  logic              seeAck,
  input  logic              seeRetry,
  input  logic              seeErr,
  output logic              monValid,
  output logic [1:0]        monCode
);
  dpCtrl_t   ctrl;
  logic      inWindow;
  logic      reqMisaligned;
  logic      reqRoHit;
  logic      reqWrite;
  termCode_e monCodeE;

  esp_control u_ctrl (
    .clk(clk), .rstN(rstN), .extMasterEn(extMasterEn), .busStart(busStart),
    .busyIn(busyIn), .inWindow(inWindow), .reqMisaligned(reqMisaligned),
    .reqRoHit(reqRoHit), .reqWrite(reqWrite), .ctrl(ctrl), .ackOut(ackOut),
    .errOut(errOut), .retryOut(retryOut), .passThru(passThru)
  );

  esp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
    .WIN_BASE(WIN_BASE), .RO_MASK(RO_MASK), .RESET_BASE(RESET_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .inWindow(inWindow), .reqMisaligned(reqMisaligned),
    .reqRoHit(reqRoHit), .reqWrite(reqWrite), .rdData(rdData)
  );

  esp_monitor u_mon (
    .clk(clk), .rstN(rstN), .seeAck(seeAck), .seeRetry(seeRetry),
    .seeErr(seeErr), .monValid(monValid), .monCode(monCodeE)
  );

  assign monCode = monCodeE;

endmodule

// File: tb/ext_slave_port_tb.sv
module ext_slave_port_tb;
  localparam logic [15:0] WIN_BASE = 16'h4000;
  localparam logic [7:0]  RO_MASK = 8'h81;
  localparam logic [31:0] RESET_BASE = 32'h5A00_0000;

  logic clk = 0;
  logic rstN = 0;
  logic extMasterEn = 0, busStart = 0, busWrite = 0, busyIn = 0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic seeAck = 0, seeRetry = 0, seeErr = 0;
  logic ackOut, errOut, retryOut, passThru, monValid;
  logic [31:0] rdData;
  logic [1:0] monCode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] model [8];
  logic [31:0] expRd = '0;
  logic errPrevM = 0;

  ext_slave_port u_dut (
    .clk(clk), .rstN(rstN), .extMasterEn(extMasterEn), .busStart(busStart),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata), .busyIn(busyIn),
    .ackOut(ackOut), .errOut(errOut), .retryOut(retryOut), .rdData(rdData),
    .passThru(passThru), .seeAck(seeAck), .seeRetry(seeRetry), .seeErr(seeErr),
    .monValid(monValid), .monCode(monCode)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 ack, 2 retry, 3 error (bench encoding of {err,retry,ack})
  function automatic int expTerm(input logic [15:0] a, input logic wr, input logic bz);
    if (a[1:0] != 2'b00 || (wr && RO_MASK[a[4:2]])) return 3;
    if (bz) return 2;
    return 1;
  endfunction

  function automatic int termOf();
    return errOut ? 3 : retryOut ? 2 : ackOut ? 1 : 0;
  endfunction

  task automatic access(input logic [15:0] a, input logic wr, input logic [31:0] d,
                        input logic bz, input logic en, input string req);
    bit inWin;
    int want;
    logic ptSeen;
    int earlyTerm;
    @(negedge clk);
    busAddr = a; busWrite = wr; busWdata = d; busyIn = bz; extMasterEn = en;
    busStart = 1;
    @(negedge clk);
    busStart = 0; busyIn = 0;
    ptSeen = passThru;
    earlyTerm = termOf();
    @(negedge clk);
    inWin = (a[15:5] == WIN_BASE[15:5]);
    if (!en) begin
      check(ptSeen == 0 && termOf() == 0 && earlyTerm == 0, req,
            "disabled strobe answered", {ptSeen, 30'd0, termOf()}, 0);
    end else if (!inWin) begin
      check(ptSeen == 1, req, "passThru pulse", ptSeen, 1);
      check(termOf() == 0 && passThru == 0, req, "out-of-window termination",
            {passThru, 30'd0, termOf()}, 0);
    end else begin
      want = expTerm(a, wr, bz);
      check(termOf() == want && earlyTerm == 0, req, "termination",
            termOf(), want);
      if (want == 1 && wr) model[a[4:2]] = d;
      if (want == 1 && !wr) expRd = model[a[4:2]];
      check(rdData == expRd, "R3", "rdData", rdData, expRd);
    end
  endtask

  task automatic monStep(input logic a, input logic r, input logic e, input string req);
    int want;
    seeAck = a; seeRetry = r; seeErr = e;
    @(negedge clk);
    want = (e && !errPrevM) ? 3 : r ? 2 : a ? 1 : 0;
    errPrevM = e;
    check(monCode == 2'(want) && monValid == (want != 0), req, "monitor code",
          {monValid, monCode}, {(want != 0), 2'(want)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) model[i] = RESET_BASE + 32'(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check({ackOut, errOut, retryOut, passThru, monValid} == 0 && rdData == 0,
          "R2", "reset outputs", {ackOut, errOut, retryOut, passThru, monValid}, 0);

    // R3: reset values of every register
    for (int i = 0; i < 8; i++) access(WIN_BASE + 16'(i * 4), 0, 0, 0, 1, "R3");
    // R3: writes then reads
    access(16'h4008, 1, 32'hCAFE_0001, 0, 1, "R3");
    access(16'h4008, 0, 0, 0, 1, "R3");
    access(16'h4014, 1, 32'h1234_5678, 0, 1, "R2");
    access(16'h4014, 0, 0, 0, 1, "R3");
    // R4 and R9: read-only writes, misaligned
    access(16'h4000, 1, 32'hDEAD_BEEF, 0, 1, "R9");
    access(16'h401C, 1, 32'hDEAD_BEEF, 0, 1, "R4");
    access(16'h4000, 0, 0, 0, 1, "R9");
    access(16'h400A, 1, 32'h0BAD_0BAD, 0, 1, "R4");
    access(16'h4008, 0, 0, 0, 1, "R4");
    // R5: busy retry, no write
    access(16'h400C, 1, 32'h7777_7777, 1, 1, "R5");
    access(16'h400C, 0, 0, 0, 1, "R5");
    // R6: error beats retry
    access(16'h4001, 0, 0, 1, 1, "R6");
    access(16'h4000, 1, 32'h1, 1, 1, "R6");
    // R7: outside the window
    access(16'h4020, 1, 32'h5555_5555, 0, 1, "R7");
    access(16'h3FFC, 0, 0, 0, 1, "R7");
    // R1: disabled
    access(16'h4010, 1, 32'h9999_9999, 0, 0, "R1");
    access(16'h4010, 0, 0, 0, 1, "R1");

    // R8: strobe held over the pending edge with a new address
    @(negedge clk);
    extMasterEn = 1; busAddr = 16'h4018; busWrite = 0; busyIn = 0; busStart = 1;
    @(negedge clk);
    busAddr = 16'h4004; busWrite = 1; busWdata = 32'hFFFF_0000;
    @(negedge clk);
    busStart = 0;
    expRd = model[6];
    check(ackOut == 1 && rdData == expRd && passThru == 0, "R8", "first access ack",
          {ackOut, rdData}, {1'b1, expRd});
    @(negedge clk);
    check(termOf() == 0 && passThru == 0, "R8", "pending strobe ignored",
          {passThru, 30'd0, termOf()}, 0);
    access(16'h4004, 0, 0, 0, 1, "R8");

    // random accesses
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = 16'h3FF0 + 16'($urandom_range(0, 63));
      access(a, 1'($urandom), $urandom, ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 9) != 0), "R2");
    end

    // monitor directed
    @(negedge clk);
    monStep(0, 0, 0, "R10");
    monStep(1, 0, 0, "R10");
    monStep(1, 1, 0, "R10");
    monStep(1, 1, 1, "R10");
    monStep(0, 0, 1, "R11");
    monStep(1, 0, 1, "R11");
    monStep(0, 0, 0, "R10");
    monStep(0, 1, 1, "R10");
    // monitor random
    for (int n = 0; n < 300; n++)
      monStep(1'($urandom), 1'($urandom), 1'($urandom), "R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule